// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates a virtual address into a physical address with one lookup per cycle. It holds 32 translations of 8 KB pages. Any translation may occupy any slot. Every slot compares its stored virtual page number against the incoming one in parallel. The match vector then steers an AND-OR select that picks the frame number and the protection bits of the matching slot. The 13 offset bits below the page number go through to the physical address unchanged.

Each slot also carries protection bits. There is a read enable and a write enable for each of two privilege levels. A lookup that finds its page but is not allowed for the current mode and access kind reports a protection fault instead of a translation. Misses are reported, and software resolves them. Software writes a new translation through a fill port. The slot written is chosen by a round-robin pointer. A single flush input drops every translation at once. The result of a lookup is registered and appears one cycle after the request.

Top module: `tlb_xlate`

## Requirements
- R1: A request with `lk_valid` high produces, on the next cycle, `rsp_valid` high with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high. With no request, all four are low on the next cycle.
- R2: When exactly one valid slot holds the page number `lk_vaddr[42:13]` and access is allowed, the response is a hit with `rsp_paddr[33:13]` equal to that slot's frame number.
- R3: On a hit, `rsp_paddr[12:0]` equals `lk_vaddr[12:0]` of the request.
- R4: When no valid slot holds the page number, the response is a miss with no fault and `rsp_paddr` zero.
- R5: When more than one valid slot holds the page number, the response is a miss.
- R6: `fill_perm` bit 0 is kernel read, bit 1 user read, bit 2 kernel write and bit 3 user write; the bit checked is index {`lk_write`,`lk_user`}. A clear bit on a single match gives `rsp_fault` with `rsp_paddr` zero.
- R7: A fill writes the slot at the round-robin pointer, marks it valid and advances the pointer by one. The pointer wraps from 31 to 0 and is 0 after reset.
- R8: `flush_all` invalidates every slot in one cycle. A fill in the same cycle is dropped, and the pointer does not move.
- R9: After reset every slot is invalid and all response outputs are low.
- R10: A lookup issued in the same cycle as a fill or flush sees the contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 43 | Virtual address: page number 42:13, offset 12:0 |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_en | input | 1 | Write a translation at the round-robin slot |
| fill_vpn | input | 30 | Virtual page number to store |
| fill_pfn | input | 21 | Physical frame number to store |
| fill_perm | input | 4 | Protection bits, layout per R6 |
| flush_all | input | 1 | Invalidate every slot |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No single matching slot |
| rsp_fault | output | 1 | Matching slot forbids this access |
| rsp_paddr | output | 34 | Physical address on hit, zero otherwise |

## Verification
All 32 slots are filled with distinct pages whose protection nibbles run through every value twice. Each slot is then looked up in all four combinations of mode and access kind, with a different offset each time. This sweep separates a wrong permission bit index from a wrong frame select and from a broken offset path. Page numbers that were never filled confirm the miss path. A 33rd fill shows that the pointer wraps onto slot 0. A refill of an existing page creates a duplicate and must turn that page into a miss. Fill and flush are then driven in the same cycle as lookups, and a flush is combined with a fill. The final sweep shows that a flush neither moves the pointer nor lets the dropped fill through.

// File: rtl/tlb_pkg.sv
// Package: shared sizes and the permission bit layout of the translation buffer.
// Assumes: permission nibble is indexed by {write, user}.
package tlb_pkg;
    localparam int unsigned TLB_ENTRIES = 32;
    localparam int unsigned TLB_VPN_W   = 30;
    localparam int unsigned TLB_PFN_W   = 21;
    localparam int unsigned TLB_OFF_W   = 13;
    localparam int unsigned TLB_PERM_W  = 4;

    // Select the permission bit for a given access kind and mode.
    function automatic logic perm_allows(input logic [TLB_PERM_W-1:0] perm,
                                         input logic is_write,
                                         input logic is_user);
        return perm[{is_write, is_user}];
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
// Module: storage of all translation slots plus the round-robin fill pointer.
// Assumes: flush has priority over fill; flush leaves the pointer alone.
module tlb_entry_store #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES,
    parameter int unsigned VPN_W   = tlb_pkg::TLB_VPN_W,
    parameter int unsigned PFN_W   = tlb_pkg::TLB_PFN_W,
    parameter int unsigned PERM_W  = tlb_pkg::TLB_PERM_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic [PERM_W-1:0]  fill_perm,
    input  logic               flush_all,
    output logic [ENTRIES-1:0] valid_o,
    output logic [VPN_W-1:0]   tag_o  [ENTRIES],
    output logic [PFN_W-1:0]   pfn_o  [ENTRIES],
    output logic [PERM_W-1:0]  perm_o [ENTRIES],
    output logic [IDX_W-1:0]   ptr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic             do_fill;
    logic [IDX_W-1:0] ptr_q;

    assign do_fill = fill_en && !flush_all;
    assign ptr_o   = ptr_q;

    // Advance the replacement pointer on each accepted fill, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (do_fill) begin
            ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        logic sel;
        assign sel = do_fill && (ptr_q == IDX_W'(gi));

        // Valid bit: cleared by reset or flush, set by a fill aimed at this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_all) begin
                valid_o[gi] <= 1'b0;
            end else if (sel) begin
                valid_o[gi] <= 1'b1;
            end
        end

        // Payload: page number, frame number and protection of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_o[gi]  <= '0;
                pfn_o[gi]  <= '0;
                perm_o[gi] <= '0;
            end else if (sel) begin
                tag_o[gi]  <= fill_vpn;
                pfn_o[gi]  <= fill_pfn;
                perm_o[gi] <= fill_perm;
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
// Module: parallel page-number compare over every slot.
// Assumes: a valid lookup result needs exactly one matching slot.
module tlb_match #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES,
    parameter int unsigned VPN_W   = tlb_pkg::TLB_VPN_W
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [VPN_W-1:0]   tag_i [ENTRIES],
    input  logic [VPN_W-1:0]   vpn_i,
    output logic [ENTRIES-1:0] match_o,
    output logic               single_o
);
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match_o[gi] = valid_i[gi] && (tag_i[gi] == vpn_i);
    end

    // Exactly one bit set: non-zero and clearing the lowest set bit leaves zero.
    always_comb begin
        single_o = (match_o != '0) && ((match_o & (match_o - 1'b1)) == '0);
    end
endmodule

// File: rtl/tlb_select.sv
// Module: AND-OR select of the frame number and protection bits of the matching slot.
// Assumes: match vector is one-hot when the result is used.
module tlb_select #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES,
    parameter int unsigned PFN_W   = tlb_pkg::TLB_PFN_W,
    parameter int unsigned PERM_W  = tlb_pkg::TLB_PERM_W
) (
    input  logic [ENTRIES-1:0] match_i,
    input  logic [PFN_W-1:0]   pfn_i  [ENTRIES],
    input  logic [PERM_W-1:0]  perm_i [ENTRIES],
    output logic [PFN_W-1:0]   pfn_o,
    output logic [PERM_W-1:0]  perm_o
);
    // OR together the payload of every slot whose compare bit is set.
    always_comb begin
        pfn_o  = '0;
        perm_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_i[i]) begin
                pfn_o  = pfn_o  | pfn_i[i];
                perm_o = perm_o | perm_i[i];
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
// Module: top of the translation buffer; registered lookup response, fill and flush.
// Assumes: software handles misses and faults; lookups see state before the current edge.
module tlb_xlate #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES,
    parameter int unsigned VPN_W   = tlb_pkg::TLB_VPN_W,
    parameter int unsigned PFN_W   = tlb_pkg::TLB_PFN_W,
    parameter int unsigned OFF_W   = tlb_pkg::TLB_OFF_W,
    localparam int unsigned PERM_W = tlb_pkg::TLB_PERM_W,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PFN_W + OFF_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr
);
    logic [ENTRIES-1:0] valid_vec;
    logic [VPN_W-1:0]   tag_arr  [ENTRIES];
    logic [PFN_W-1:0]   pfn_arr  [ENTRIES];
    logic [PERM_W-1:0]  perm_arr [ENTRIES];
    logic [IDX_W-1:0]   fill_ptr;
    logic [ENTRIES-1:0] match_vec;
    logic               one_match;
    logic [PFN_W-1:0]   sel_pfn;
    logic [PERM_W-1:0]  sel_perm;
    logic               allowed;
    logic               grant;

    tlb_entry_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PERM_W(PERM_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .flush_all(flush_all),
        .valid_o(valid_vec), .tag_o(tag_arr), .pfn_o(pfn_arr),
        .perm_o(perm_arr), .ptr_o(fill_ptr)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) match_i (
        .valid_i(valid_vec), .tag_i(tag_arr),
        .vpn_i(lk_vaddr[VA_W-1:OFF_W]),
        .match_o(match_vec), .single_o(one_match)
    );

    tlb_select #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .PERM_W(PERM_W)) select_i (
        .match_i(match_vec), .pfn_i(pfn_arr), .perm_i(perm_arr),
        .pfn_o(sel_pfn), .perm_o(sel_perm)
    );

    // Permission decision for the current access kind and privilege mode.
    always_comb begin
        allowed = tlb_pkg::perm_allows(sel_perm, lk_write, lk_user);
        grant   = lk_valid && one_match && allowed;
    end

    // Register the lookup outcome and the translated address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= grant;
            rsp_miss  <= lk_valid && !one_match;
            rsp_fault <= lk_valid && one_match && !allowed;
            rsp_paddr <= grant ? {sel_pfn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
// Module: protocol checker for the translation buffer, attached by bind.
// Assumes: observes top ports plus the slot valid vector and fill pointer.
module tlb_xlate_chk #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned OFF_W   = 13,
    parameter int unsigned PA_W    = 34,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [OFF_W-1:0]   lk_off,
    input logic               fill_en,
    input logic               flush_all,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [IDX_W-1:0]   ptr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_off)));
    p_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_paddr == '0);
    p_ptr_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all) |=>
            ptr == (($past(ptr) == LAST_IDX) ? '0 : $past(ptr) + 1'b1));
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> valid_vec == '0);
    p_flush_keeps_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> $stable(ptr));
    p_miss_after_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_all) && lk_valid) |=> rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .ENTRIES(ENTRIES), .OFF_W(OFF_W), .PA_W(PA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .lk_off(lk_vaddr[OFF_W-1:0]), .fill_en(fill_en), .flush_all(flush_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .valid_vec(valid_vec), .ptr(fill_ptr)
);

// File: tb/tlb_xlate_tb_top.sv
// Bench: sweeps every slot in every mode, plus wrap, duplicate, same-cycle and flush cases.
module tlb_xlate_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [42:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        fill_en = 1'b0;
    logic [29:0] fill_vpn = '0;
    logic [20:0] fill_pfn = '0;
    logic [3:0]  fill_perm = '0;
    logic        flush_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [33:0] rsp_paddr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Reference model built from the requirements.
    logic [29:0] m_vpn  [N];
    logic [20:0] m_pfn  [N];
    logic [3:0]  m_perm [N];
    logic        m_val  [N];
    int          m_ptr = 0;

    always #4ns clk = ~clk;

    tlb_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    function automatic logic [29:0] vpn_of(input int i);
        return 30'h2A5C_0000 + 30'(i) * 30'h0001_0307;
    endfunction
    function automatic logic [20:0] pfn_of(input int i);
        return 21'h15A3C ^ (21'(i) * 21'h0421);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; a lookup is compared against the model state before the edge.
    task automatic step(input logic fe, input logic [29:0] fv, input logic [20:0] fp,
                        input logic [3:0] fm, input logic fl, input logic lv,
                        input logic [29:0] lvpn, input logic [12:0] loff,
                        input logic lw, input logic lu, input string req);
        int cnt = 0;
        int idx = 0;
        logic [63:0] exp;
        @(negedge clk);
        fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_perm = fm; flush_all = fl;
        lk_valid = lv; lk_vaddr = {lvpn, loff}; lk_write = lw; lk_user = lu;
        for (int i = 0; i < N; i++) begin
            if (m_val[i] && m_vpn[i] == lvpn) begin cnt++; idx = i; end
        end
        if (!lv)                       exp = '0;
        else if (cnt != 1)             exp = {26'd0, 4'b1010, 34'd0};
        else if (m_perm[idx][{lw, lu}]) exp = {26'd0, 4'b1100, m_pfn[idx], loff};
        else                           exp = {26'd0, 4'b1001, 34'd0};
        @(negedge clk);
        fill_en = 1'b0; flush_all = 1'b0; lk_valid = 1'b0;
        chk(req, {26'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, exp);
        if (fl) begin
            for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        end else if (fe) begin
            m_vpn[m_ptr] = fv; m_pfn[m_ptr] = fp; m_perm[m_ptr] = fm; m_val[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic fill(input logic [29:0] v, input logic [20:0] p, input logic [3:0] m);
        step(1'b1, v, p, m, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R7 fill idle response");
    endtask

    task automatic look(input logic [29:0] v, input logic [12:0] o, input logic w,
                        input logic u, input string req);
        step(1'b0, '0, '0, '0, 1'b0, 1'b1, v, o, w, u, req);
    endtask

    task automatic sweep_model(input string req);
        for (int i = 0; i < N; i++) begin
            if (m_val[i]) look(m_vpn[i], 13'(i * 97), 1'b0, 1'b0, req);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0; m_val[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R9: outputs low while and right after reset
        chk("R9 reset outputs", {26'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, '0);
        rst_n = 1'b1;
        look(vpn_of(0), 13'h1, 1'b0, 1'b0, "R9 empty after reset misses");

        // R7 and R2: fill every slot, protection nibble = slot index mod 16
        for (int i = 0; i < N; i++) fill(vpn_of(i), pfn_of(i), 4'(i));

        // R2 R3 R6: every slot, every mode and access kind, varied offsets
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < 4; k++) begin
                look(vpn_of(i), 13'(i * 251 + k * 1777), k[1], k[0], "R2 R3 R6 sweep");
            end
        end

        // R4: never-filled pages miss
        for (int i = N; i < N + 16; i++) look(vpn_of(i), 13'h1FFF, 1'b1, 1'b1, "R4 unfilled miss");

        // R7: 33rd fill wraps to slot 0
        fill(vpn_of(100), pfn_of(100), 4'hF);
        look(vpn_of(0), 13'h0, 1'b0, 1'b0, "R7 wrap evicts slot 0");
        look(vpn_of(100), 13'h0ABC, 1'b1, 1'b1, "R7 wrap new page hits");

        // R5: duplicate page (lands on slot 1) makes that page miss
        fill(vpn_of(5), pfn_of(200), 4'hF);
        look(vpn_of(5), 13'h0055, 1'b0, 1'b0, "R5 duplicate match misses");
        look(vpn_of(1), 13'h0011, 1'b0, 1'b0, "R7 overwritten slot 1 misses");

        // R10: fill and lookup of the same page in one cycle sees old contents
        step(1'b1, vpn_of(300), pfn_of(300), 4'hF, 1'b0, 1'b1, vpn_of(300), 13'h0777,
             1'b0, 1'b0, "R10 same-cycle fill not visible");
        look(vpn_of(300), 13'h0777, 1'b0, 1'b0, "R10 fill visible next cycle");

        // R8 and R10: flush with a fill and a lookup in the same cycle
        step(1'b1, vpn_of(400), pfn_of(400), 4'hF, 1'b1, 1'b1, vpn_of(300), 13'h0123,
             1'b0, 1'b0, "R10 same-cycle flush not visible");
        look(vpn_of(300), 13'h0123, 1'b0, 1'b0, "R8 flushed page misses");
        look(vpn_of(400), 13'h0123, 1'b0, 1'b0, "R8 fill during flush dropped");
        look(vpn_of(10), 13'h0123, 1'b0, 1'b0, "R8 old slot flushed");

        // R8 R7: pointer unchanged by flush, checked by refilling past the wrap
        for (int i = 0; i < N + 2; i++) fill(vpn_of(500 + i), pfn_of(500 + i), 4'(i + 3));
        sweep_model("R7 R8 pointer after flush");
        look(vpn_of(500), 13'h0042, 1'b0, 1'b0, "R7 R8 first refill evicted");
        look(vpn_of(501), 13'h0042, 1'b0, 1'b0, "R7 R8 second refill evicted");

        // R1: idle cycle gives a quiet response
        step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R1 idle quiet");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule